// File: doc/BRIEF.md
# Selectable-Tap Timer Clock Prescaler

This block feeds an 8-bit timer/counter with a one-cycle clock-enable pulse, `tick`. All logic runs on one clock, `clk`. The count source is chosen by `alt_sel`:

- With `alt_sel` low, the source is the main I/O clock itself, so every cycle of `clk` is a source cycle.
- With `alt_sel` high, the source is an alternate oscillator. It appears here as the gated enable `alt_tick`, and only cycles with `alt_tick` high are source cycles.

A free-running 10-bit prescale counter advances once per source cycle. A 3-bit code selects what reaches `tick`: nothing, every source cycle, or one of six divided taps (8, 32, 64, 128, 256, 1024).

Software can pulse `pre_clr` to clear the prescale counter. The next divided pulse then arrives after a complete, known interval.

The select code is captured each cycle into a small mode state machine with three states:

- `MODE_STOP` (no ticks).
- `MODE_DIRECT` (pass-through).
- `MODE_DIVIDE` (divided tap, with the tap width held beside the state).

From any state, the transition on every clock is to the state that the current code selects:

- `GO_STOP` on code 000.
- `GO_DIRECT` on code 001.
- `GO_DIVIDE` on codes 010 to 111.

Reset places the machine in `MODE_STOP`.

Top module: `tmr_prescaler`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `tick` is low whatever `div_code` holds; reset clears the prescale counter to zero and enters `MODE_STOP`.
- R2: With `div_code` = 000, `tick` never goes high, whatever the other inputs do.
- R3: With `div_code` = 001, `tick` is high in exactly the source cycles: every cycle when `alt_sel` = 0, and the cycles with `alt_tick` = 1 when `alt_sel` = 1.
- R4: `alt_sel` = 0 makes `alt_tick` irrelevant. With `alt_sel` = 1, the counter advances only in cycles with `alt_tick` = 1, and `tick` is never high in a cycle with `alt_tick` = 0.
- R5: Codes 010, 011, 100, 101, 110 and 111 divide by 8, 32, 64, 128, 256 and 1024. `tick` is high for one cycle in each source cycle in which the low log2(N) counter bits are all ones, so consecutive pulses are N source cycles apart.
- R6: A cycle with `pre_clr` = 1 clears the counter and produces no divided pulse. Under a divide-by-N code, the first pulse afterwards comes in the N-th source cycle after the strobe cycle.
- R7: A new `div_code` takes effect from the following cycle and leaves the counter alone. For example, switching from /32 to /8 in the cycle where the counter holds 9 gives the first /8 pulse when the counter reaches 15.
- R8: The prescale counter is 10 bits wide and wraps from 1023 to 0 without disturbing the tap spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_sel | input | 1 | 1 selects the alternate source, 0 the main clock |
| alt_tick | input | 1 | Enable marking one alternate-source cycle |
| div_code | input | 3 | Tap select: 000 stop, 001 /1, 010 /8, 011 /32, 100 /64, 101 /128, 110 /256, 111 /1024 |
| pre_clr | input | 1 | One-cycle strobe that clears the prescale counter |
| tick | output | 1 | One-cycle enable for the timer/counter |

## Verification
The assertions assume that `alt_tick` and `pre_clr` are clean, synchronous single-bit levels in `clk`. They also assume `div_code` is stable for the whole cycle it is sampled in. The bench respects this by changing every input just after the falling edge and reading `tick` one time unit later. Expected pulse positions are computed arithmetically from the strobe cycle, the tap width and the count of alternate-source events. Each divided code is measured over three full intervals after a strobe, with `alt_tick` toggling while unselected.

// File: rtl/tpre_pkg.sv
package tpre_pkg;

    localparam int unsigned CNT_W = 10;
    localparam int unsigned TAP_W = 4;

    typedef enum logic [1:0] {
        MODE_STOP   = 2'd0,
        MODE_DIRECT = 2'd1,
        MODE_DIVIDE = 2'd2
    } mode_e;

    // number of low counter bits that define a tap interval
    function automatic logic [TAP_W-1:0] tap_bits(input logic [2:0] code);
        logic [TAP_W-1:0] b;
        unique case (code)
            3'b010:  b = 4'd3;
            3'b011:  b = 4'd5;
            3'b100:  b = 4'd6;
            3'b101:  b = 4'd7;
            3'b110:  b = 4'd8;
            3'b111:  b = 4'd10;
            default: b = 4'd0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tpre_src.sv
module tpre_src (
    input  logic alt_sel,
    input  logic alt_tick,
    output logic src_en
);
    always_comb begin
        src_en = alt_sel ? alt_tick : 1'b1;
    end
endmodule

// File: rtl/tpre_counter.sv
module tpre_counter #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_en,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (src_en) cnt <= cnt + 1'b1;
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));                                            // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_en && !clr) |=> $stable(cnt));                             // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en && !clr) |=> (cnt == $past(cnt) + 1'b1));                // R8
endmodule

// File: rtl/tpre_mode_fsm.sv
module tpre_mode_fsm
    import tpre_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   div_code,
    input  logic         src_en,
    input  logic         clr,
    input  logic [W-1:0] cnt,
    output logic         tick
);
    mode_e            mode_q, mode_d;
    logic [TAP_W-1:0] tap_q, tap_d;
    logic [W-1:0]     mask;
    logic             roll;

    // next-state decode: GO_STOP / GO_DIRECT / GO_DIVIDE from any state
    always_comb begin
        tap_d = tap_bits(div_code);
        unique case (div_code)
            3'b000:  mode_d = MODE_STOP;
            3'b001:  mode_d = MODE_DIRECT;
            default: mode_d = MODE_DIVIDE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STOP;
            tap_q  <= '0;
        end else begin
            mode_q <= mode_d;
            tap_q  <= tap_d;
        end
    end

    always_comb begin
        mask = ~({W{1'b1}} << tap_q);
        roll = ((cnt & mask) == mask);
    end

    // outputs
    always_comb begin
        unique case (mode_q)
            MODE_STOP:   tick = 1'b0;
            MODE_DIRECT: tick = src_en;
            MODE_DIVIDE: tick = src_en && !clr && roll;
            default:     tick = 1'b0;
        endcase
    end

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STOP) |-> !tick);                                // R2
    AST_TICK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> src_en);                                                // R4
    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && mode_q == MODE_DIVIDE) |-> !tick);                       // R6
    AST_DIV_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_q == MODE_DIVIDE) |=> ((cnt & $past(mask)) == '0)); // R5
    AST_MODE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code == 3'b000) |=> (mode_q == MODE_STOP));                 // R7
    AST_MODE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code == 3'b001) |=> (mode_q == MODE_DIRECT));               // R7
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tpre_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alt_sel,
    input  logic       alt_tick,
    input  logic [2:0] div_code,
    input  logic       pre_clr,
    output logic       tick
);
    logic             src_en;
    logic [CNT_W-1:0] cnt;

    tpre_src u_src (
        .alt_sel  (alt_sel),
        .alt_tick (alt_tick),
        .src_en   (src_en)
    );

    tpre_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_en (src_en),
        .clr    (pre_clr),
        .cnt    (cnt)
    );

    tpre_mode_fsm #(.W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_code (div_code),
        .src_en   (src_en),
        .clr      (pre_clr),
        .cnt      (cnt),
        .tick     (tick)
    );

    AST_ALT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_sel && !alt_tick) |-> !tick);                               // R4
endmodule

// File: tb/tmr_prescaler_bench.sv
module tmr_prescaler_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       alt_sel;
    logic       alt_tick;
    logic [2:0] div_code;
    logic       pre_clr;
    logic       tick;

    int errors = 0;
    int checks = 0;

    tmr_prescaler u_tmr_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .alt_sel  (alt_sel),
        .alt_tick (alt_tick),
        .div_code (div_code),
        .pre_clr  (pre_clr),
        .tick     (tick)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic at, input logic clr, output logic t);
        @(negedge clk);
        alt_tick = at;
        pre_clr  = clr;
        #1 t = tick;
    endtask

    // R5 / R6 / R8: spacing of one divided code from a clear strobe
    task automatic run_div(input logic [2:0] code, input int n);
        logic t;
        int cnt_t = 0;
        int first = -1;
        int last  = -1;
        int bad   = 0;
        alt_sel  = 1'b0;
        div_code = code;
        cyc(1'b0, 1'b0, t);
        cyc(1'b0, 1'b0, t);
        cyc(1'b0, 1'b1, t);
        chk(t == 1'b0, "R6 no pulse in strobe cycle", t, 0);
        for (int c = 1; c <= 3 * n; c++) begin
            cyc(c[0], 1'b0, t);       // alt_tick toggles unselected: R4
            if (t) begin
                cnt_t++;
                if (first < 0) first = c;
                if (c % n != 0) bad++;
                last = c;
            end
        end
        chk(first == n, "R6 first pulse after strobe", first, n);
        chk(cnt_t == 3 && bad == 0, "R5 pulse count and spacing", cnt_t, 3);
        chk(last == 3 * n, "R8 spacing across wrap", last, 3 * n);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic t;
        int   n_hi;
        int   ev;
        int   mis;
        int   first;
        rst_n    = 1'b0;
        alt_sel  = 1'b0;
        alt_tick = 1'b0;
        pre_clr  = 1'b0;
        div_code = 3'b001;

        // R1: reset holds tick low even with pass-through code
        cyc(1'b0, 1'b0, t);
        chk(t == 1'b0, "R1 tick low in reset", t, 0);
        cyc(1'b1, 1'b0, t);
        rst_n = 1'b1;
        #1 t = tick;
        chk(t == 1'b0, "R1 tick low first cycle after reset", t, 0);
        cyc(1'b0, 1'b0, t);
        chk(t == 1'b1, "R3 direct after reset", t, 1);

        // R2: stop code, with strobes and alt toggles
        div_code = 3'b000;
        cyc(1'b0, 1'b0, t);
        n_hi = 0;
        for (int c = 0; c < 1200; c++) begin
            cyc(c[1], (c % 97) == 0, t);
            if (t) n_hi++;
        end
        chk(n_hi == 0, "R2 no pulses in stop", n_hi, 0);

        // R3: direct from main clock
        div_code = 3'b001;
        cyc(1'b0, 1'b0, t);
        n_hi = 0;
        for (int c = 0; c < 20; c++) begin
            cyc(c[0], 1'b0, t);
            if (t) n_hi++;
        end
        chk(n_hi == 20, "R3 direct every cycle", n_hi, 20);

        // R3 / R4: direct from alternate source
        alt_sel = 1'b1;
        mis = 0;
        for (int c = 0; c < 30; c++) begin
            cyc((c % 3) == 1, 1'b0, t);
            if (t != ((c % 3) == 1)) mis++;
        end
        chk(mis == 0, "R3 direct follows alt_tick", mis, 0);

        // R5 / R6 / R8: every divided code
        run_div(3'b010, 8);
        run_div(3'b011, 32);
        run_div(3'b100, 64);
        run_div(3'b101, 128);
        run_div(3'b110, 256);
        run_div(3'b111, 1024);

        // R4: /8 on alternate source, event every third cycle
        alt_sel  = 1'b1;
        div_code = 3'b010;
        cyc(1'b0, 1'b0, t);
        cyc(1'b0, 1'b1, t);
        ev = 0; mis = 0; n_hi = 0;
        for (int c = 1; c <= 120; c++) begin
            logic at;
            at = (c % 3) == 0;
            if (at) ev++;
            cyc(at, 1'b0, t);
            if (t) n_hi++;
            if (t != (at && (ev % 8) == 0)) mis++;
        end
        chk(mis == 0, "R4 alt pulses per 8 events", mis, 0);
        chk(n_hi == 5, "R4 alt pulse count", n_hi, 5);

        // R7: switch /32 -> /8 without clearing
        alt_sel  = 1'b0;
        div_code = 3'b011;
        cyc(1'b0, 1'b0, t);
        cyc(1'b0, 1'b1, t);
        first = -1;
        for (int c = 1; c <= 30; c++) begin
            if (c == 10) div_code = 3'b010;
            cyc(1'b0, 1'b0, t);
            if (t && first < 0) first = c;
        end
        chk(first == 16, "R7 early first pulse after code change", first, 16);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule